// File: doc/BRIEF.md
# Two-Phase Direct-Decode Control Sequencer

This block is the control unit of a small 4-bit machine that has no microcode store. One state flop alternates between a fetch phase and an execute phase. In the fetch phase the program ROM drives the data bus, and the byte on the bus is captured as the opcode. In the execute phase the opcode's fields drive the datapath directly. They name one bus source and one bus destination, choose where the memory address comes from, optionally switch off the upper address byte so that accesses land in zero page, and optionally ask for one more program counter step so that an inline constant byte is consumed.

Every control output is a flop. The sequencer works out the next phase and the next opcode one cycle early and decodes from them. Each output therefore holds the value for the cycle it is used in, and no decode logic sits between the flops and the datapath. The opcode layout runs from the least significant bit upward: destination select [2:0], source select [4:3], zero-page bit 5, address-source bit 6 and extra-step bit 7.

Top module: `nibble_direct_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the state returns to fetch and the opcode register clears, so the cycle that follows shows the fetch output pattern.
- R2: Fetch and execute alternate, one clock cycle each, for as long as `rst` stays low.
- R3: In fetch the outputs are `src_oe`=4'b0010 (program ROM), `ir_ld`=1, `dst_ld`=0, `mem_addr_sel`=1, `addr_hi_off`=0 and `pc_inc`=1.
- R4: The opcode is `rom_data` as sampled at the rising edge that ends fetch. The value of `rom_data` during execute has no effect on any output.
- R5: In execute, `ir_ld`=0 and `dst_ld` = 1 << opcode[2:0]. Bit 0 loads the A register, 1 the B register, 2 the address low byte, 3 the address high byte, 4 the PC low byte, 5 the PC high byte, 6 is the RAM write and 7 the display.
- R6: In execute, `src_oe` = 1 << opcode[4:3]. Bit 0 enables the A/B pair, 1 the program ROM, 2 the RAM read and 3 the keypad buffer.
- R7: In execute, `addr_hi_off` equals opcode[5]. A value of 1 disables the address-high register, which gives zero-page addressing.
- R8: In execute, `mem_addr_sel` equals opcode[6]. A value of 1 takes the address from the program counter and 0 takes it from the address registers.
- R9: In execute, `pc_inc` is opcode[7] AND opcode[6]. With bit 7 set and bit 6 clear, there is no increment.
- R10: A reset applied during an execute cycle makes the next cycle a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_data | input | 8 | Bus byte read from program ROM; captured as the opcode at the end of fetch |
| src_oe | output | 4 | One-hot bus source enables |
| dst_ld | output | 8 | One-hot bus destination load strobes (execute only) |
| ir_ld | output | 1 | Opcode register load (fetch only) |
| mem_addr_sel | output | 1 | 1: memory address from program counter; 0: from address registers |
| addr_hi_off | output | 1 | Disables the address-high register (zero page) |
| pc_inc | output | 1 | Program counter increment request |

## Verification
The bench drives a fresh byte on `rom_data` during every execute cycle. A design that captured the opcode in the wrong phase, or decoded straight from the bus, would change its strobes in the middle of execute. Opcodes with bit 7 set and bit 6 clear are checked for the absence of a PC step; a design that stepped on bit 7 alone would skip a program byte. Across the opcodes every destination code and every source code appears, and the zero-page and address-source bits are toggled independently, so a swapped field or a shifted one-hot shows up as a wrong strobe. A reset that lands in an execute cycle must be followed by a fetch; a design that only toggled its phase flop would go on to execute the stale opcode.

// File: rtl/nds_pkg.sv
package nds_pkg;
  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_EXEC  = 1'b1
  } phase_t;

  localparam int DEF_SRC_SEL_W = 2;
  localparam int DEF_DST_SEL_W = 3;
endpackage

// File: rtl/nds_phase.sv
module nds_phase
  import nds_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] rom_data,
  output phase_t           phase_d,
  output logic [OPC_W-1:0] opc_d
);
  phase_t           phase_q;
  logic [OPC_W-1:0] opc_q;

  // look-ahead values feed the registered control outputs
  always_comb begin
    phase_d = (phase_q == PH_FETCH) ? PH_EXEC : PH_FETCH;
    opc_d   = (phase_q == PH_FETCH) ? rom_data : opc_q;
    if (rst) begin
      phase_d = PH_FETCH;
      opc_d   = '0;
    end
  end

  always_ff @(posedge clk) begin
    phase_q <= phase_d;
    opc_q   <= opc_d;
  end

  // R2: one flop alternates the phases
  assert_fetch_to_exec_R2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_FETCH) |=> (phase_q == PH_EXEC));
  assert_exec_to_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_EXEC) |=> (phase_q == PH_FETCH));
  // R4: the opcode is held through execute
  assert_opc_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_EXEC) |=> $stable(opc_q));
  // R1: reset clears the opcode
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (opc_q == '0 && phase_q == PH_FETCH));
endmodule

// File: rtl/nds_onehot_dec.sv
module nds_onehot_dec #(
  parameter int SEL_W = 2,
  localparam int N_OUT = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             en,
  output logic [N_OUT-1:0] hot
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_line
    assign hot[i] = en && (sel == SEL_W'(i));
  end
endmodule

// File: rtl/nds_ctl_reg.sv
module nds_ctl_reg #(
  parameter int N_SRC       = 4,
  parameter int N_DST       = 8,
  parameter int ROM_SRC_IDX = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_d,
  input  logic [N_DST-1:0] dst_d,
  input  logic             ir_ld_d,
  input  logic             sel_d,
  input  logic             zp_d,
  input  logic             inc_d,
  output logic [N_SRC-1:0] src_oe,
  output logic [N_DST-1:0] dst_ld,
  output logic             ir_ld,
  output logic             mem_addr_sel,
  output logic             addr_hi_off,
  output logic             pc_inc
);
  localparam logic [N_SRC-1:0] ROM_HOT = N_SRC'(1) << ROM_SRC_IDX;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_oe       <= ROM_HOT;
      dst_ld       <= '0;
      ir_ld        <= 1'b1;
      mem_addr_sel <= 1'b1;
      addr_hi_off  <= 1'b0;
      pc_inc       <= 1'b1;
    end else begin
      src_oe       <= src_d;
      dst_ld       <= dst_d;
      ir_ld        <= ir_ld_d;
      mem_addr_sel <= sel_d;
      addr_hi_off  <= zp_d;
      pc_inc       <= inc_d;
    end
  end

  // R6: exactly one bus source every cycle
  assert_one_source_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(src_oe) == 1);
  // R5: at most one destination, never together with the opcode load
  assert_one_dest_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dst_ld) && !(ir_ld && (dst_ld != '0)));
  // R3: fetch pattern
  assert_fetch_pattern_R3: assert property (@(posedge clk) disable iff (rst)
    ir_ld |-> (src_oe == ROM_HOT && mem_addr_sel && pc_inc && !addr_hi_off));
  // R2: the opcode load and the execute strobes alternate
  assert_alternate_R2: assert property (@(posedge clk) disable iff (rst)
    ir_ld |=> !ir_ld);
  // R9: an extra step only when the address comes from the program counter
  assert_step_needs_pc_R9: assert property (@(posedge clk) disable iff (rst)
    pc_inc |-> mem_addr_sel);
endmodule

// File: rtl/nibble_direct_sequencer.sv
module nibble_direct_sequencer
  import nds_pkg::*;
#(
  parameter int SRC_SEL_W   = DEF_SRC_SEL_W,
  parameter int DST_SEL_W   = DEF_DST_SEL_W,
  parameter int ROM_SRC_IDX = 1,
  localparam int N_SRC = 1 << SRC_SEL_W,
  localparam int N_DST = 1 << DST_SEL_W,
  localparam int OPC_W = DST_SEL_W + SRC_SEL_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] rom_data,
  output logic [N_SRC-1:0] src_oe,
  output logic [N_DST-1:0] dst_ld,
  output logic             ir_ld,
  output logic             mem_addr_sel,
  output logic             addr_hi_off,
  output logic             pc_inc
);
  localparam int SRC_LO   = DST_SEL_W;
  localparam int ZP_BIT   = DST_SEL_W + SRC_SEL_W;
  localparam int PCA_BIT  = ZP_BIT + 1;
  localparam int STEP_BIT = ZP_BIT + 2;
  localparam logic [N_SRC-1:0] ROM_HOT = N_SRC'(1) << ROM_SRC_IDX;

  phase_t           phase_d;
  logic [OPC_W-1:0] opc_d;
  logic             exec_d;
  logic [N_SRC-1:0] src_exec;
  logic [N_DST-1:0] dst_exec;
  logic [N_SRC-1:0] src_d;
  logic             sel_d, zp_d, inc_d;

  nds_phase #(.OPC_W(OPC_W)) u_phase (
    .clk(clk), .rst(rst), .rom_data(rom_data),
    .phase_d(phase_d), .opc_d(opc_d)
  );

  assign exec_d = (phase_d == PH_EXEC);

  nds_onehot_dec #(.SEL_W(SRC_SEL_W)) u_src_dec (
    .sel(opc_d[SRC_LO +: SRC_SEL_W]), .en(exec_d), .hot(src_exec)
  );

  nds_onehot_dec #(.SEL_W(DST_SEL_W)) u_dst_dec (
    .sel(opc_d[DST_SEL_W-1:0]), .en(exec_d), .hot(dst_exec)
  );

  always_comb begin
    if (exec_d) begin
      src_d = src_exec;
      sel_d = opc_d[PCA_BIT];
      zp_d  = opc_d[ZP_BIT];
      inc_d = opc_d[STEP_BIT] & opc_d[PCA_BIT];
    end else begin
      src_d = ROM_HOT;
      sel_d = 1'b1;
      zp_d  = 1'b0;
      inc_d = 1'b1;
    end
  end

  nds_ctl_reg #(.N_SRC(N_SRC), .N_DST(N_DST), .ROM_SRC_IDX(ROM_SRC_IDX)) u_ctl (
    .clk(clk), .rst(rst),
    .src_d(src_d), .dst_d(dst_exec), .ir_ld_d(!exec_d),
    .sel_d(sel_d), .zp_d(zp_d), .inc_d(inc_d),
    .src_oe(src_oe), .dst_ld(dst_ld), .ir_ld(ir_ld),
    .mem_addr_sel(mem_addr_sel), .addr_hi_off(addr_hi_off), .pc_inc(pc_inc)
  );

  // R7: zero page never asserted during fetch
  assert_no_zp_in_fetch_R7: assert property (@(posedge clk) disable iff (rst)
    ir_ld |-> !addr_hi_off);
  // R10: a reset edge always leads into a fetch cycle
  assert_reset_to_fetch_R10: assert property (@(posedge clk)
    rst |=> ir_ld);
endmodule

// File: tb/nibble_direct_sequencer_bench.sv
module nibble_direct_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] rom_data = 8'h00;
  logic [3:0] src_oe;
  logic [7:0] dst_ld;
  logic       ir_ld, mem_addr_sel, addr_hi_off, pc_inc;

  typedef struct {
    logic [15:0] v;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  localparam logic [15:0] FETCH_EXP = {4'b0010, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1};

  always #10 clk = ~clk;

  nibble_direct_sequencer u_nibble_direct_sequencer (
    .clk(clk), .rst(rst), .rom_data(rom_data),
    .src_oe(src_oe), .dst_ld(dst_ld), .ir_ld(ir_ld),
    .mem_addr_sel(mem_addr_sel), .addr_hi_off(addr_hi_off), .pc_inc(pc_inc)
  );

  // execute pattern written from R5..R9
  function automatic logic [15:0] exec_exp(logic [7:0] op);
    logic [3:0] s;
    logic [7:0] d;
    s = 4'b0001 << op[4:3];
    d = 8'h01 << op[2:0];
    return {s, d, 1'b0, op[6], op[5], op[7] & op[6]};
  endfunction

  task automatic push(logic [15:0] v, string tag);
    exp_t e;
    e.v = v;
    e.tag = tag;
    q.push_back(e);
  endtask

  // entered at a falling edge within a fetch cycle; leaves at the next fetch
  task automatic run_op(logic [7:0] op, string ftag);
    push(FETCH_EXP, ftag);
    rom_data = op;
    @(negedge clk);
    push(exec_exp(op), "R4 R5 R6 R7 R8 R9 exec");
    rom_data = ~op;  // R4: bus noise during execute
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    #1;
    if (q.size() != 0) begin
      exp_t e;
      logic [15:0] act;
      e = q.pop_front();
      act = {src_oe, dst_ld, ir_ld, mem_addr_sel, addr_hi_off, pc_inc};
      n_cmp++;
      if (act !== e.v) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", e.tag, act, e.v);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    push(FETCH_EXP, "R1 reset held");
    @(negedge clk);
    rst = 1'b0;
    run_op(8'h00, "R1 R3 first fetch");
    run_op(8'h01, "R2 R3 fetch");
    run_op(8'h0A, "R2 R3 fetch");
    run_op(8'h13, "R3 fetch");
    run_op(8'h1C, "R3 fetch");
    run_op(8'h25, "R3 fetch");
    run_op(8'h4E, "R3 fetch");
    run_op(8'hCF, "R3 fetch");
    run_op(8'h88, "R3 fetch");  // R9: bit7 without bit6
    run_op(8'hE9, "R3 fetch");
    run_op(8'hFF, "R3 fetch");
    run_op(8'h7A, "R3 fetch");
    // R10: reset lands in an execute cycle
    push(FETCH_EXP, "R3 fetch");
    rom_data = 8'hCA;
    @(negedge clk);
    push(exec_exp(8'hCA), "R10 exec before reset");
    rst = 1'b1;
    @(negedge clk);
    push(FETCH_EXP, "R10 fetch during reset");
    @(negedge clk);
    rst = 1'b0;
    run_op(8'h96, "R10 fetch after reset");
    run_op(8'h31, "R2 fetch");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule